// File: doc/BRIEF.md
# Serial Receiver with Address Filtering

This block receives asynchronous serial frames on a single input line and turns them into bytes for a host. A frame opens with a low start bit. Eight or nine data bits follow, least significant bit first, and a high stop bit closes it. Bit timing comes from an 8-bit reload value. That value sets a sample-tick divider, and a speed select picks 16 ticks per bit (fast) or 64 ticks per bit (normal). Every bit is decided by a two-of-three vote taken at the middle of the bit.

Completed frames go into a two-entry queue. Each entry holds the data byte, the ninth bit and the framing-error flag. The host reads the head of the queue and pops it with a one-cycle pulse. In nine-bit mode an address filter can be switched on. While it is on, only frames whose ninth bit is 1 reach the queue. A node can therefore sleep through data meant for other nodes and wake only on address frames. An overrun flag records a frame lost because the queue was full. That flag halts reception until the receive enable is dropped.

Top module: `uart_addr_rx`

## Requirements
- R1: The bit period is (reload+1)*16 clocks when the fast select is 1, and (reload+1)*64 clocks when it is 0. Frames sent at that period are received correctly.
- R2: Reception runs only while both the port enable and the receive enable are 1. A frame sent while either is 0 leaves the queue empty.
- R3: In 8-bit mode the first data bit on the line lands in bit 0 of the read data and the eighth lands in bit 7. The read ninth bit is 0.
- R4: In 9-bit mode the bit after the eighth data bit is returned on the ninth-bit output with its frame.
- R5: With 9-bit mode and the address filter both on, a frame whose ninth bit is 0 is discarded: it does not become available and no interrupt is raised. A frame whose ninth bit is 1 is queued.
- R6: With the address filter off, every completed frame is queued, whatever its ninth bit.
- R7: A stop bit that samples low sets the framing flag stored with that frame. The flag output shows the flag of the entry at the queue head.
- R8: If a frame completes while the queue holds two entries and no pop is made in that cycle, the overrun flag is set and the frame is dropped. Later frames are ignored while the flag is set.
- R9: Driving the receive enable to 0 clears the overrun flag. Reception then resumes once the enable returns to 1.
- R10: The available flag is 1 while the queue is non-empty. A pop removes the head. The interrupt output is 1 exactly when the available flag and the interrupt enable are both 1.
- R11: A start edge whose line reads high again at the middle of the start bit is rejected, and nothing is queued.
- R12: After reset the available, overrun and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| port_en_i | input | 1 | Serial port enable |
| rx_en_i | input | 1 | Continuous receive enable; 0 clears overrun |
| fast_i | input | 1 | 1: 16 ticks per bit, 0: 64 ticks per bit |
| reload_i | input | 8 | Tick divider reload; tick every reload+1 clocks |
| nine_bit_i | input | 1 | Nine data bits per frame |
| addr_det_i | input | 1 | Address filter enable (9-bit mode only) |
| irq_en_i | input | 1 | Interrupt enable |
| pop_i | input | 1 | One-cycle pulse that pops the queue head |
| rd_data_o | output | 8 | Data byte at queue head |
| rd_bit9_o | output | 1 | Ninth bit at queue head |
| rd_ferr_o | output | 1 | Framing flag of the queue head |
| avail_o | output | 1 | Queue non-empty |
| ovr_err_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench runs all 256 byte values through 8-bit mode at the shortest bit period. This shows whether bit order and per-bit voting are right for every pattern. A sample of nine-bit values, taken with the address filter both off and on, separates storing the ninth bit from using it to discard frames. Frames at three further rate settings in both speed modes separate the two prescales and the reload arithmetic. A short low pulse, a low stop bit, a third frame into a full queue and frames sent while disabled each check a rejection path at the ports.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic       ferr;
        logic       bit9;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                restart,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);

    typedef struct packed {
        logic [RELOAD_W-1:0] cnt;
    } baud_st_t;

    baud_st_t d, q;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (!run || restart) begin
            d.cnt = '0;
        end else if (q.cnt == reload) begin
            d.cnt = '0;
            tick  = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int FAST_OS = 16,
    parameter int SLOW_OS = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_i,
    input  logic      run,
    input  logic      tick,
    input  logic      fast,
    input  logic      nine_bit,
    output logic      restart,
    output logic      done,
    output rx_entry_t ent
);

    localparam int CW = $clog2(SLOW_OS);

    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
        rx_state_e  st;
        logic [CW-1:0] cnt;
        logic [1:0] ones;
        logic [3:0] idx;
        logic [8:0] sh;
        logic       done;
        rx_entry_t  ent;
    } frame_st_t;

    frame_st_t d, q;

    logic          rx_s;
    logic [CW-1:0] mid, last;
    logic [3:0]    last_idx;
    logic          samp, decide, endbit, bitv;
    logic [1:0]    ones_n;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        restart  = 1'b0;
        rx_s     = q.sync[1];
        d.sync   = {q.sync[0], rx_i};
        d.prev   = rx_s;
        mid      = fast ? CW'(FAST_OS / 2) : CW'(SLOW_OS / 2);
        last     = fast ? CW'(FAST_OS - 1) : CW'(SLOW_OS - 1);
        last_idx = nine_bit ? 4'd8 : 4'd7;
        samp     = tick && ((q.cnt == mid - 1'b1) || (q.cnt == mid) || (q.cnt == mid + 1'b1));
        ones_n   = q.ones + {1'b0, samp & rx_s};
        decide   = tick && (q.cnt == mid + 1'b1);
        endbit   = tick && (q.cnt == last);
        bitv     = ones_n[1];

        if (q.st == ST_IDLE) begin
            if (q.prev && !rx_s) begin
                d.st    = ST_START;
                d.cnt   = '0;
                d.ones  = '0;
                restart = 1'b1;
            end
        end else begin
            if (tick) begin
                d.ones = ones_n;
                d.cnt  = q.cnt + 1'b1;
            end
            if (endbit) begin
                d.cnt  = '0;
                d.ones = '0;
            end
            case (q.st)
                ST_START: begin
                    if (decide && bitv) begin
                        d.st = ST_IDLE;
                    end else if (endbit) begin
                        d.st  = ST_DATA;
                        d.idx = '0;
                    end
                end
                ST_DATA: begin
                    if (decide) d.sh = {bitv, q.sh[8:1]};
                    if (endbit) begin
                        if (q.idx == last_idx) d.st = ST_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (decide) begin
                        d.done      = 1'b1;
                        d.ent.data  = nine_bit ? q.sh[7:0] : q.sh[8:1];
                        d.ent.bit9  = nine_bit & q.sh[8];
                        d.ent.ferr  = ~bitv;
                        d.st        = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end

        if (!run) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.ones = '0;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
            q.prev <= 1'b1;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign ent  = q.ent;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t wr_ent,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [NW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t d, q;

    always_comb begin
        d = q;
        if (pop) begin
            d.rd = (q.rd == PW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        end
        if (push) begin
            d.mem[q.wr] = wr_ent;
            d.wr        = (q.wr == PW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        if (push && !pop)      d.cnt = q.cnt + 1'b1;
        else if (pop && !push) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rd];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == NW'(DEPTH));

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int RELOAD_W = 8,
    parameter int DEPTH    = 2,
    parameter int FAST_OS  = 16,
    parameter int SLOW_OS  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_i,
    input  logic                port_en_i,
    input  logic                rx_en_i,
    input  logic                fast_i,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic                nine_bit_i,
    input  logic                addr_det_i,
    input  logic                irq_en_i,
    input  logic                pop_i,
    output logic [7:0]          rd_data_o,
    output logic                rd_bit9_o,
    output logic                rd_ferr_o,
    output logic                avail_o,
    output logic                ovr_err_o,
    output logic                irq_o
);

    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t   d, q;
    logic      run, tick, restart, done;
    logic      empty, full, pop_eff, accept, push;
    rx_entry_t ent, head;

    assign run = port_en_i & rx_en_i & ~q.ovr;

    uart_rx_baud #(.RELOAD_W(RELOAD_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .reload  (reload_i),
        .tick    (tick)
    );

    uart_rx_frame #(.FAST_OS(FAST_OS), .SLOW_OS(SLOW_OS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_i     (rx_i),
        .run      (run),
        .tick     (tick),
        .fast     (fast_i),
        .nine_bit (nine_bit_i),
        .restart  (restart),
        .done     (done),
        .ent      (ent)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .wr_ent (ent),
        .pop    (pop_eff),
        .head   (head),
        .empty  (empty),
        .full   (full)
    );

    always_comb begin
        d       = q;
        pop_eff = pop_i & ~empty;
        accept  = done & run & ~(nine_bit_i & addr_det_i & ~ent.bit9);
        push    = accept & (~full | pop_eff);
        if (accept && full && !pop_eff) d.ovr = 1'b1;
        if (!rx_en_i)                   d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data_o = head.data;
    assign rd_bit9_o = head.bit9;
    assign rd_ferr_o = head.ferr;
    assign avail_o   = ~empty;
    assign ovr_err_o = q.ovr;
    assign irq_o     = ~empty & irq_en_i;

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en_i,
    input logic rx_en_i,
    input logic nine_bit_i,
    input logic addr_det_i,
    input logic irq_en_i,
    input logic avail_o,
    input logic rd_bit9_o,
    input logic ovr_err_o,
    input logic irq_o
);

    // R10
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (avail_o && irq_en_i));

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !ovr_err_o);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err_o && rx_en_i) |=> ovr_err_o);

    // R2
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!port_en_i || !rx_en_i) && !avail_o) |=> !avail_o);

    // R5
    addr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(avail_o) && $past(nine_bit_i && addr_det_i)) |-> rd_bit9_o);

endmodule

bind uart_addr_rx uart_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en_i  (port_en_i),
    .rx_en_i    (rx_en_i),
    .nine_bit_i (nine_bit_i),
    .addr_det_i (addr_det_i),
    .irq_en_i   (irq_en_i),
    .avail_o    (avail_o),
    .rd_bit9_o  (rd_bit9_o),
    .ovr_err_o  (ovr_err_o),
    .irq_o      (irq_o)
);

// File: tb/sim_uart_addr_rx.sv
`timescale 1ns/1ps
module sim_uart_addr_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       port_en = 1'b1, rx_en = 1'b1, fast = 1'b1;
    logic [7:0] reload = 8'd0;
    logic       nine = 1'b0, addr_det = 1'b0, irq_en = 1'b0, pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rd_ferr, avail, ovr, irq;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    uart_addr_rx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx),
        .port_en_i  (port_en),
        .rx_en_i    (rx_en),
        .fast_i     (fast),
        .reload_i   (reload),
        .nine_bit_i (nine),
        .addr_det_i (addr_det),
        .irq_en_i   (irq_en),
        .pop_i      (pop),
        .rd_data_o  (rd_data),
        .rd_bit9_o  (rd_bit9),
        .rd_ferr_o  (rd_ferr),
        .avail_o    (avail),
        .ovr_err_o  (ovr),
        .irq_o      (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [8:0] v, input int nb, input logic stp, input int per);
        @(negedge clk) rx = 1'b0;
        repeat (per) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            rx = v[b];
            repeat (per) @(negedge clk);
        end
        rx = stp;
        repeat (per) @(negedge clk);
        rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 avail", avail, 0);
        chk("R12 ovr", ovr, 0);
        chk("R12 irq", irq, 0);

        // R3 every byte, 8-bit mode, 16 clocks per bit
        for (int v = 0; v < 256; v++) begin
            send(9'(v), 8, 1'b1, 16);
            chk("R10 avail after frame", avail, 1);
            chk("R3 data", rd_data, v);
            chk("R3 ninth bit zero", rd_bit9, 0);
            do_pop();
            chk("R10 empty after pop", avail, 0);
        end

        // R4 R6 nine-bit, filter off
        nine = 1'b1;
        for (int i = 0; i < 32; i++) begin
            logic [8:0] w;
            w = {i[0], 8'((i * 37 + 5) & 255)};
            send(w, 9, 1'b1, 16);
            chk("R6 queued", avail, 1);
            chk("R4 data", rd_data, int'(w[7:0]));
            chk("R4 ninth bit", rd_bit9, int'(w[8]));
            do_pop();
        end

        // R5 filter on, R10 interrupt gating
        addr_det = 1'b1;
        irq_en = 1'b1;
        for (int i = 0; i < 16; i++) begin
            logic [8:0] w;
            w = {i[0], 8'((i * 91 + 3) & 255)};
            send(w, 9, 1'b1, 16);
            if (w[8]) begin
                chk("R5 address frame queued", avail, 1);
                chk("R5 address data", rd_data, int'(w[7:0]));
                chk("R5 address ninth bit", rd_bit9, 1);
                chk("R10 irq with data", irq, 1);
                do_pop();
                chk("R10 irq cleared", irq, 0);
            end else begin
                chk("R5 data frame dropped", avail, 0);
                chk("R5 no irq", irq, 0);
            end
        end
        addr_det = 1'b0;
        nine = 1'b0;

        // R10 interrupt enable off
        irq_en = 1'b0;
        send(9'h0C3, 8, 1'b1, 16);
        chk("R10 no irq when disabled", irq, 0);
        chk("R10 avail", avail, 1);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R10 irq when enabled", irq, 1);
        do_pop();
        irq_en = 1'b0;

        // R1 other rates
        reload = 8'd2;
        send(9'h0A5, 8, 1'b1, 48);
        chk("R1 fast reload 2", rd_data, 8'hA5);
        do_pop();
        fast = 1'b0;
        reload = 8'd0;
        send(9'h03C, 8, 1'b1, 64);
        chk("R1 normal reload 0", rd_data, 8'h3C);
        do_pop();
        reload = 8'd1;
        send(9'h1E7, 9, 1'b1, 128);
        chk("R1 normal reload 1 avail", avail, 1);
        chk("R1 normal reload 1", rd_data, 8'hE7);
        do_pop();

        // R11 glitch at 64 clocks per bit
        fast = 1'b1;
        reload = 8'd3;
        @(negedge clk) rx = 1'b0;
        repeat (6) @(negedge clk);
        rx = 1'b1;
        repeat (150) @(negedge clk);
        chk("R11 glitch rejected", avail, 0);
        send(9'h05A, 8, 1'b1, 64);
        chk("R11 frame after glitch", rd_data, 8'h5A);
        do_pop();
        reload = 8'd0;

        // R7 framing flag per entry
        send(9'h011, 8, 1'b0, 16);
        send(9'h022, 8, 1'b1, 16);
        chk("R7 head ferr", rd_ferr, 1);
        chk("R7 head data", rd_data, 8'h11);
        do_pop();
        chk("R7 next ferr", rd_ferr, 0);
        chk("R7 next data", rd_data, 8'h22);
        do_pop();

        // R8 overrun
        send(9'h001, 8, 1'b1, 16);
        send(9'h002, 8, 1'b1, 16);
        chk("R8 no overrun at two", ovr, 0);
        send(9'h003, 8, 1'b1, 16);
        chk("R8 overrun set", ovr, 1);
        do_pop();
        send(9'h004, 8, 1'b1, 16);
        chk("R8 head after first pop", rd_data, 8'h02);
        do_pop();
        chk("R8 blocked frame not queued", avail, 0);
        chk("R8 flag held", ovr, 1);

        // R9 clear by receive enable
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk);
        chk("R9 overrun cleared", ovr, 0);
        rx_en = 1'b1;
        send(9'h077, 8, 1'b1, 16);
        chk("R9 resumed", rd_data, 8'h77);
        do_pop();

        // R2 enables
        port_en = 1'b0;
        send(9'h0F0, 8, 1'b1, 16);
        chk("R2 port off", avail, 0);
        port_en = 1'b1;
        rx_en = 1'b0;
        send(9'h0F1, 8, 1'b1, 16);
        chk("R2 receive off", avail, 0);
        rx_en = 1'b1;
        send(9'h0F2, 8, 1'b1, 16);
        chk("R2 enabled", rd_data, 8'hF2);
        do_pop();

        report();
        $finish;
    end

endmodule